// File: doc/BRIEF.md
# Framed SPI Master with Stream FIFOs

This block is a serial peripheral interface master. Words enter through a valid/ready transmit stream into a 16-entry FIFO. The shift engine sends them MSB first on the serial clock, samples the input line, and places the received word into a 16-entry receive FIFO. That FIFO drains through a valid/ready receive stream. The serial clock comes from a two-stage divider: an even prescale value times a rate divider plus one. The idle level and the sampling edge follow the usual four clock-polarity/phase modes. The word length runs from 1 to 16 bits.

Each 32-bit transmit word carries two control bits in its upper part. Bit 31 tags the last word of a frame, and bit 30 tags a word whose received data is thrown away. In block mode, chip select stays low from word to word. With stall enabled it also stays low, with the clock parked, while the transmit FIFO is empty, until a word tagged as last has gone out. A pause input holds off new words while the transmit FIFO is being preloaded. Loopback feeds the serial output back to the sampling input.

Back-pressure rules: `tx_ready` is low while the transmit FIFO holds 16 words, and a transfer happens on a clock edge where valid and ready are both high. `rx_valid` stays high while the receive FIFO is not empty. The engine starts no word unless the receive FIFO will still have a free slot once any word being delivered in the same cycle is counted. A stalled `rx_ready` therefore holds words back in the transmit FIFO and never loses data.

Top module: `spim_block_ctrl`

## Requirements
- R1: Each FIFO holds 16 words. `tx_ready` is low while the transmit FIFO is full. The engine starts no word while the receive FIFO has no free slot, and no received word is ever dropped.
- R2: The serial clock period is P*(D+1) input clocks, where P is `prescale` with bit 0 forced to zero, a value of 0 is taken as 2, and D is `rate_div`.
- R3: A word has `word_len_m1`+1 bits, sent MSB first. Received data is right-aligned with all upper bits zero, and exactly `word_len_m1`+1 rising clock edges occur per word.
- R4: `sclk` idles at `cpol`. With `cpha`=0, data is sampled on the first edge of each bit; with `cpha`=1, on the second. Modes 0 to 3 are {cpol,cpha} = 00, 01, 10, 11.
- R5: After a word with bit 31 set, the frame always ends and chip select is released, even in block mode with more words queued.
- R6: A word with bit 30 set is shifted normally, but nothing enters the receive FIFO for it.
- R7: While `pause` is high, no new frame starts.
- R8: With `block_mode`=1 and `stall_en`=1, an empty transmit FIFO keeps chip select low, `sclk` at `cpol` and `busy` high until a word with bit 31 set has been sent.
- R9: With `block_mode`=1 and `stall_en`=0, queued words share one frame, and the frame ends as soon as the transmit FIFO is empty after a word.
- R10: With `block_mode`=0, every word is its own frame.
- R11: Only `cs_n[cs_sel]` is driven low during a frame. `out_disable`=1 keeps every `cs_n` line high.
- R12: With `loopback`=1, the received data equals the transmitted data, and `miso` is ignored.
- R13: A pulse on `tx_flush` empties the transmit FIFO, and a pulse on `rx_flush` empties the receive FIFO, each without affecting the other.
- R14: After reset, every `cs_n` is high, `sclk`=0, `busy`=0, `tx_empty`=1, `tx_ready`=1 and `rx_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit FIFO can take a word |
| tx_data | input | 32 | Bit 31 last-of-frame, bit 30 skip-receive, low bits data |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 16 | Received word, right-aligned |
| pause | input | 1 | Hold off new frames |
| tx_flush | input | 1 | Empty transmit FIFO |
| rx_flush | input | 1 | Empty receive FIFO |
| prescale | input | 8 | Even clock prescale value |
| rate_div | input | 8 | Second divider stage, divides by value+1 |
| word_len_m1 | input | 4 | Word length minus one |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Sample on second edge when 1 |
| block_mode | input | 1 | Keep chip select low between words |
| stall_en | input | 1 | Hold frame open over an empty FIFO |
| out_disable | input | 1 | Force all chip selects high |
| cs_sel | input | 2 | Chip-select line to drive |
| loopback | input | 1 | Internal serial output to input |
| tx_empty | output | 1 | Transmit FIFO empty |
| busy | output | 1 | Engine inside a frame |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The bench targets the seams between words. If the engine mis-handles an underrun in block mode, it either releases chip select too early (R8) or keeps the frame open after the tagged last word (R5). A wrong frame decision shows up as an extra or missing chip-select fall in the frame count. Data is checked through loopback in all four modes, so a swapped sampling edge gives shifted data. A held `miso` with a 12-bit word shows whether the upper bits are masked. The receive back-pressure case queues seventeen words with `rx_ready` held low. A design that ignores the receive level would overwrite or lose the seventeenth word. The divider is timed between serial clock rising edges, including an odd prescale and a zero prescale.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int TX_W     = 32;
  localparam int LAST_BIT = 31;
  localparam int SKIP_BIT = 30;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_HOLD, ST_TRAIL} eng_state_t;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign out_data = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (!do_push && do_pop) count <= count - 1'b1;
    end
  end

  // R1: level never exceeds the capacity
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
  parameter int PRE_W  = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [RATE_W-1:0] rate_div,
  output logic              tick
);
  logic [PRE_W-2:0]  half, half_m1, pre_cnt;
  logic [RATE_W-1:0] rate_cnt;
  logic              pre_wrap;

  // even prescale: half period of the first stage is prescale/2, zero taken as 1
  assign half     = (prescale[PRE_W-1:1] == '0) ? (PRE_W-1)'(1) : prescale[PRE_W-1:1];
  assign half_m1  = half - (PRE_W-1)'(1);
  assign pre_wrap = (pre_cnt == half_m1);
  assign tick     = en && pre_wrap && (rate_cnt == rate_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
    end else if (!en) begin
      pre_cnt  <= '0;
      rate_cnt <= '0;
    end else if (pre_wrap) begin
      pre_cnt  <= '0;
      rate_cnt <= (rate_cnt == rate_div) ? '0 : rate_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spim_engine.sv
module spim_engine
  import spim_pkg::*;
#(
  parameter int MAX_W = 16,
  localparam int LW   = $clog2(MAX_W),
  localparam int EW   = LW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [LW-1:0]    wl_m1,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             block_mode,
  input  logic             stall_en,
  input  logic             loopback,
  input  logic             can_start,
  input  logic [TX_W-1:0]  tx_word,
  input  logic             miso,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [MAX_W-1:0] rx_word,
  output logic             clk_en,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_active,
  output logic             busy
);
  eng_state_t       st;
  logic [MAX_W-1:0] txw, rxsh, rx_nx;
  logic [LW-1:0]    out_idx;
  logic [EW-1:0]    ecnt, last_e;
  logic             cur_last, cur_skip, sclk_q, mosi_q;
  logic             shifting, sample_now, drive_now, word_end, carry_on, take, miso_in;

  assign last_e     = {wl_m1, 1'b1};
  assign shifting   = tick && (st == ST_SHIFT);
  assign sample_now = shifting && (ecnt[0] == cpha);
  assign drive_now  = shifting && (ecnt[0] != cpha) && (ecnt != last_e);
  assign word_end   = shifting && (ecnt == last_e);
  assign carry_on   = block_mode && !cur_last;
  assign miso_in    = loopback ? mosi_q : miso;
  assign rx_nx      = sample_now ? {rxsh[MAX_W-2:0], miso_in} : rxsh;
  assign take       = can_start && ((st == ST_IDLE) || (st == ST_HOLD) || (word_end && carry_on));

  assign tx_pop  = take;
  assign rx_push = word_end && !cur_skip;
  assign rx_word = rx_nx;
  assign clk_en  = (st == ST_SHIFT) || (st == ST_TRAIL);
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;
  assign busy    = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      txw       <= '0;
      rxsh      <= '0;
      out_idx   <= '0;
      ecnt      <= '0;
      cur_last  <= 1'b0;
      cur_skip  <= 1'b0;
      sclk_q    <= 1'b0;
      mosi_q    <= 1'b0;
      cs_active <= 1'b0;
    end else if (take) begin
      st        <= ST_SHIFT;
      cs_active <= 1'b1;
      sclk_q    <= cpol;
      cur_last  <= tx_word[LAST_BIT];
      cur_skip  <= tx_word[SKIP_BIT];
      txw       <= tx_word[MAX_W-1:0];
      rxsh      <= '0;
      ecnt      <= '0;
      if (!cpha) begin
        mosi_q  <= tx_word[wl_m1];
        out_idx <= wl_m1 - 1'b1;
      end else begin
        out_idx <= wl_m1;
      end
    end else begin
      unique case (st)
        ST_IDLE: begin
          sclk_q    <= cpol;
          mosi_q    <= 1'b0;
          cs_active <= 1'b0;
        end
        ST_SHIFT: if (tick) begin
          sclk_q <= ~sclk_q;
          rxsh   <= rx_nx;
          if (drive_now) begin
            mosi_q  <= txw[out_idx];
            out_idx <= out_idx - 1'b1;
          end
          if (ecnt == last_e) st <= (carry_on && stall_en) ? ST_HOLD : ST_TRAIL;
          else ecnt <= ecnt + 1'b1;
        end
        ST_HOLD: sclk_q <= cpol;
        ST_TRAIL: if (tick) begin
          st        <= ST_IDLE;
          cs_active <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8: a stalled frame keeps select asserted with the clock parked
  assert_hold_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |-> (cs_active && sclk_q == cpol));
  // R5: the tagged last word always closes the frame
  assert_last_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_end && cur_last) |=> (st == ST_TRAIL));
  // R4: clock rests at its idle level between frames
  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st) == ST_IDLE && $stable(cpol)) |-> (sclk_q == cpol));
endmodule

// File: rtl/spim_block_ctrl.sv
module spim_block_ctrl
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int MAX_W      = 16,
  parameter int NUM_CS     = 4,
  parameter int PRE_W      = 8,
  parameter int RATE_W     = 8,
  localparam int LW        = $clog2(MAX_W),
  localparam int CSW       = $clog2(NUM_CS),
  localparam int CW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [31:0]       tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [MAX_W-1:0]  rx_data,
  input  logic              pause,
  input  logic              tx_flush,
  input  logic              rx_flush,
  input  logic [PRE_W-1:0]  prescale,
  input  logic [RATE_W-1:0] rate_div,
  input  logic [LW-1:0]     word_len_m1,
  input  logic              cpol,
  input  logic              cpha,
  input  logic              block_mode,
  input  logic              stall_en,
  input  logic              out_disable,
  input  logic [CSW-1:0]    cs_sel,
  input  logic              loopback,
  output logic              tx_empty,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] cs_n
);
  logic [TX_W-1:0]  tx_word;
  logic [MAX_W-1:0] rx_word;
  logic [CW-1:0]    tx_count, rx_count;
  logic [CW:0]      rx_after;
  logic             tx_full, rx_full, rx_empty;
  logic             tx_pop, rx_push, rx_room, can_start, clk_en, tick, cs_active;

  spim_fifo #(.W(TX_W), .DEPTH(FIFO_DEPTH)) tx_fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush),
    .push(tx_valid), .push_data(tx_data), .pop(tx_pop),
    .out_data(tx_word), .count(tx_count), .full(tx_full), .empty(tx_empty));

  spim_fifo #(.W(MAX_W), .DEPTH(FIFO_DEPTH)) rx_fifo_i (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush),
    .push(rx_push), .push_data(rx_word), .pop(rx_ready),
    .out_data(rx_data), .count(rx_count), .full(rx_full), .empty(rx_empty));

  assign tx_ready  = !tx_full;
  assign rx_valid  = !rx_empty;
  assign rx_after  = {1'b0, rx_count} + (CW+1)'(rx_push);
  assign rx_room   = rx_after < (CW+1)'(FIFO_DEPTH);
  assign can_start = !tx_empty && !pause && rx_room;

  spim_clkgen #(.PRE_W(PRE_W), .RATE_W(RATE_W)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .en(clk_en),
    .prescale(prescale), .rate_div(rate_div), .tick(tick));

  spim_engine #(.MAX_W(MAX_W)) engine_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wl_m1(word_len_m1),
    .cpol(cpol), .cpha(cpha), .block_mode(block_mode), .stall_en(stall_en),
    .loopback(loopback), .can_start(can_start), .tx_word(tx_word), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word), .clk_en(clk_en),
    .sclk(sclk), .mosi(mosi), .cs_active(cs_active), .busy(busy));

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = ~(cs_active && !out_disable && (cs_sel == CSW'(g)));
  end

  // R1: a delivered word always finds room in the receive FIFO
  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);
  // R7: a paused idle engine stays idle
  assert_pause_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !busy) |=> !busy);
  // R11: at most one select low, none when disabled
  assert_cs_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);
  assert_cs_disable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_disable |-> (&cs_n));
endmodule

// File: tb/spim_block_ctrl_tb.sv
module spim_block_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_valid = 0, tx_ready, rx_valid, rx_ready = 0;
  logic [31:0] tx_data = '0;
  logic [15:0] rx_data;
  logic pause = 0, tx_flush = 0, rx_flush = 0;
  logic [7:0] prescale = 8'd2, rate_div = 8'd0;
  logic [3:0] word_len_m1 = 4'd7;
  logic cpol = 0, cpha = 0, block_mode = 0, stall_en = 0, out_disable = 0, loopback = 1;
  logic [1:0] cs_sel = 2'd0;
  logic tx_empty, busy, sclk, mosi, miso = 0;
  logic [3:0] cs_n;

  int n_chk = 0, n_err = 0;
  int cyc = 0, frames = 0, rises = 0, last_rise = 0, prev_rise = 0;
  logic prev_all_hi = 1'b1, prev_sclk = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spim_block_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .pause(pause),
    .tx_flush(tx_flush), .rx_flush(rx_flush), .prescale(prescale), .rate_div(rate_div),
    .word_len_m1(word_len_m1), .cpol(cpol), .cpha(cpha), .block_mode(block_mode),
    .stall_en(stall_en), .out_disable(out_disable), .cs_sel(cs_sel), .loopback(loopback),
    .tx_empty(tx_empty), .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    prev_all_hi <= &cs_n;
    prev_sclk <= sclk;
    if (prev_all_hi && !(&cs_n)) frames <= frames + 1;
    if (!prev_sclk && sclk) begin
      rises <= rises + 1;
      prev_rise <= last_rise;
      last_rise <= cyc;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    tx_data = w;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic pop(output logic [15:0] v);
    while (!rx_valid) @(negedge clk);
    v = rx_data;
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic wait_idle(output logic [3:0] seen);
    seen = '0;
    repeat (3) @(negedge clk);
    while (busy || !tx_empty) begin
      seen = seen | ~cs_n;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic cfg(input int mode, input int wl, input bit blk, input bit stl);
    {cpol, cpha} = 2'(mode);
    word_len_m1 = 4'(wl);
    block_mode = blk;
    stall_en = stl;
    prescale = 8'd2;
    rate_div = 8'd0;
    loopback = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R14 cs_n", cs_n, 4'hF);
    chk("R14 sclk", sclk, 0);
    chk("R14 busy", busy, 0);
    chk("R14 tx_empty", tx_empty, 1);
    chk("R14 tx_ready", tx_ready, 1);
    chk("R14 rx_valid", rx_valid, 0);
  endtask

  task automatic t_fill_flush();
    cfg(0, 7, 0, 0);
    pause = 1'b1;
    for (int i = 0; i < 16; i++) push(32'(i));
    chk("R1 tx_ready at 16 words", tx_ready, 0);
    repeat (5) @(negedge clk);
    chk("R7 paused not busy", busy, 0);
    tx_flush = 1'b1; @(negedge clk); tx_flush = 1'b0;
    chk("R13 tx flushed", tx_empty, 1);
    chk("R13 tx_ready after flush", tx_ready, 1);
    pause = 1'b0;
    repeat (10) @(negedge clk);
    chk("R13 nothing sent after flush", busy, 0);
  endtask

  task automatic t_modes();
    logic [15:0] v;
    logic [3:0] s;
    for (int m = 0; m < 4; m++) begin
      cfg(m, 15, 0, 0);
      push(32'h0000_B2C5 ^ 32'(m * 16'h1111));
      wait_idle(s);
      pop(v);
      chk($sformatf("R4 R12 loopback mode %0d", m), v, 16'hB2C5 ^ 16'(m * 16'h1111));
      chk($sformatf("R4 idle sclk mode %0d", m), sclk, m / 2);
    end
  endtask

  task automatic t_mask_len();
    logic [15:0] v;
    logic [3:0] s;
    int r0;
    cfg(1, 11, 0, 0);
    loopback = 1'b0;
    miso = 1'b1;
    r0 = rises;
    push(32'h0);
    wait_idle(s);
    pop(v);
    chk("R3 right-aligned masked", v, 16'h0FFF);
    chk("R3 rising edges per word", rises - r0, 12);
    miso = 1'b0;
    loopback = 1'b1;
  endtask

  task automatic t_clock();
    logic [3:0] s;
    logic [15:0] v;
    cfg(0, 7, 0, 0);
    prescale = 8'd6; rate_div = 8'd2;
    push(32'h5A); wait_idle(s); pop(v);
    chk("R2 period 6x3", last_rise - prev_rise, 18);
    prescale = 8'd7;
    push(32'h5A); wait_idle(s); pop(v);
    chk("R2 odd prescale same as even", last_rise - prev_rise, 18);
    prescale = 8'd0;
    push(32'h5A); wait_idle(s); pop(v);
    chk("R2 zero prescale as 2", last_rise - prev_rise, 6);
  endtask

  task automatic t_nonblock();
    logic [15:0] v;
    logic [3:0] s;
    int f0;
    cfg(0, 7, 0, 0);
    pause = 1'b1;
    push(32'hA5); push(32'h3C);
    f0 = frames;
    pause = 1'b0;
    wait_idle(s);
    chk("R10 one frame per word", frames - f0, 2);
    pop(v); chk("R12 first word", v, 16'hA5);
    pop(v); chk("R12 second word", v, 16'h3C);
  endtask

  task automatic t_block_nostall();
    logic [15:0] v;
    logic [3:0] s;
    int f0;
    cfg(0, 7, 1, 0);
    pause = 1'b1;
    push(32'h11); push(32'h22); push(32'h33);
    f0 = frames;
    pause = 1'b0;
    wait_idle(s);
    chk("R9 queued words in one frame", frames - f0, 1);
    push(32'h44);
    wait_idle(s);
    chk("R9 frame closed on empty FIFO", frames - f0, 2);
    for (int i = 1; i <= 4; i++) begin
      pop(v); chk("R9 block data", v, 16'(i * 16'h11));
    end
  endtask

  task automatic t_last_in_block();
    logic [15:0] v;
    logic [3:0] s;
    int f0;
    cfg(3, 7, 1, 0);
    pause = 1'b1;
    push(32'h8000_0077); push(32'h88);
    f0 = frames;
    pause = 1'b0;
    wait_idle(s);
    chk("R5 last bit splits frame", frames - f0, 2);
    pop(v); chk("R5 data a", v, 16'h77);
    pop(v); chk("R5 data b", v, 16'h88);
  endtask

  task automatic t_stall();
    logic [15:0] v;
    logic [3:0] s;
    int f0;
    cfg(2, 7, 1, 1);
    f0 = frames;
    push(32'h5C);
    repeat (100) @(negedge clk);
    chk("R8 busy during underrun", busy, 1);
    chk("R8 select held low", cs_n[0], 0);
    chk("R8 clock parked at cpol", sclk, 1);
    push(32'h8000_00E1);
    wait_idle(s);
    chk("R8 single frame", frames - f0, 1);
    chk("R8 released after last", cs_n, 4'hF);
    pop(v); chk("R8 data a", v, 16'h5C);
    pop(v); chk("R8 data b", v, 16'hE1);
  endtask

  task automatic t_skip();
    logic [15:0] v;
    logic [3:0] s;
    cfg(0, 7, 0, 0);
    push(32'h4000_0055); push(32'h66);
    wait_idle(s);
    pop(v);
    chk("R6 skipped word absent", v, 16'h66);
    chk("R6 nothing else queued", rx_valid, 0);
  endtask

  task automatic t_cs();
    logic [15:0] v;
    logic [3:0] s;
    cfg(0, 7, 0, 0);
    cs_sel = 2'd2;
    push(32'h12); wait_idle(s); pop(v);
    chk("R11 only selected line low", s, 4'b0100);
    out_disable = 1'b1;
    push(32'h34); wait_idle(s); pop(v);
    chk("R11 disable keeps lines high", s, 4'b0000);
    out_disable = 1'b0;
    cs_sel = 2'd0;
  endtask

  task automatic t_rx_backpressure();
    logic [15:0] v;
    logic [3:0] s;
    cfg(0, 7, 0, 0);
    pause = 1'b1;
    for (int i = 0; i < 16; i++) push(32'(8'h20 + i));
    pause = 1'b0;
    push(32'h30);
    repeat (800) @(negedge clk);
    chk("R1 word held while receive full", tx_empty, 0);
    chk("R1 engine idle while receive full", busy, 0);
    for (int i = 0; i < 17; i++) begin
      pop(v); chk("R1 receive order", v, 16'(8'h20 + i));
    end
    wait_idle(s);
    rx_flush = 1'b1; @(negedge clk); rx_flush = 1'b0;
  endtask

  task automatic t_rx_flush();
    logic [3:0] s;
    cfg(0, 7, 0, 0);
    push(32'h9);
    wait_idle(s);
    pause = 1'b1;
    push(32'h7);
    rx_flush = 1'b1; @(negedge clk); rx_flush = 1'b0;
    chk("R13 receive flushed", rx_valid, 0);
    chk("R13 transmit kept", tx_empty, 0);
    tx_flush = 1'b1; @(negedge clk); tx_flush = 1'b0;
    pause = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_fill_flush();
    t_modes();
    t_mask_len();
    t_clock();
    t_nonblock();
    t_block_nostall();
    t_last_in_block();
    t_stall();
    t_skip();
    t_cs();
    t_rx_backpressure();
    t_rx_flush();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule